// File: doc/BRIEF.md
# Narrow-Port Word Read Sequencer

This block is an external-bus master for reads only. An internal requester hands it one word-wide read. The block serves that read from a device port that is one byte wide, with bursting switched off. The word is fetched as a run of separate single-byte bus transactions. Each transaction has its own address cycle and its own extra address-setup clock. It also has a single data clock, because the device answers with zero wait states.

The block drives a byte address, an active-low chip select, an active-low read strobe and a two-bit transfer-size code. The first transaction announces the full word size. Every later transaction announces a single byte.

Returned bytes are packed most-significant first into the result word. A one-clock done pulse presents the word. A new request is taken only while the sequencer is idle.

Top module: `narrow_read_seq`

## Requirements
- R1: After reset, and while reset is held, `bus_cs_n` and `bus_rd_n` are 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: One accepted request produces exactly four bus transactions. Each transaction holds `bus_cs_n` low for exactly two consecutive clocks.
- R3: During the first transaction `bus_tsiz` is 2'b00, the word-size code.
- R4: During the second, third and fourth transactions `bus_tsiz` is 2'b01, the byte-size code.
- R5: Each transaction is one address clock (`bus_cs_n` high, address and size valid), then one setup clock (`bus_cs_n` low, `bus_rd_n` high), then one data clock (`bus_rd_n` low). `bus_din` is sampled at the clock edge that ends the data clock.
- R6: The first transaction uses `req_addr` with its two low bits cleared. Each later transaction adds one to the address of the one before.
- R7: The result is big-endian. The byte of the first transaction lands in bits 31:24, and the byte of the fourth lands in bits 7:0.
- R8: `req_ready` is 1 only while idle. A request presented while busy is ignored: it changes neither the address nor the data of the transfer in progress, and it starts nothing afterwards.
- R9: `bus_cs_n` is high for at least one clock between consecutive transactions. Address and size are already stable in the clock before `bus_cs_n` falls.
- R10: `rsp_valid` is high for exactly one clock, the clock right after the fourth data clock. `rsp_data` holds the assembled word in that clock, and `req_ready` returns in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request from the internal requester |
| req_addr | input | 32 | Byte address of the requested word |
| req_ready | output | 1 | High while idle; a request is taken when `req_valid` is also high |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_data | output | 32 | Assembled word, valid while `rsp_valid` is high |
| bus_addr | output | 32 | External byte address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_tsiz | output | 2 | Transfer-size code: 00 word, 01 byte |
| bus_din | input | 8 | Byte returned by the device |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 32-bit word and an 8-bit port. That gives four beats per request and brings the whole 00-then-01 size sequence into view. A behavioural zero-wait device drives a distinct byte for each address during the data clock, and drives a marker value at all other times. A sample taken one clock early or late therefore shows up in the assembled word. Requests are aligned, unaligned, placed at the top of the address space (so the address steps reach the last byte), issued back to back and presented while busy. Every clock of each transfer is compared against the expected schedule.

// File: rtl/nrs_pkg.sv
// Shared types and helpers for the narrow-port read sequencer.
// Assumes transfer-size codes follow the 2-bit convention: word, byte, half, other.
package nrs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SETUP,
        PH_DATA,
        PH_DONE
    } phase_e;

    // Map a transfer length in bytes onto the two-bit size code.
    function automatic logic [1:0] size_code(input int nbytes);
        case (nbytes)
            4:       size_code = 2'b00;
            1:       size_code = 2'b01;
            2:       size_code = 2'b10;
            default: size_code = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/nrs_phase_fsm.sv
// Phase sequencer: walks address, setup and data clocks for each beat, then
// a done clock. Assumes a zero-wait device, so one data clock per beat.
module nrs_phase_fsm
    import nrs_pkg::*;
#(
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output phase_e            phase_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              accept_o,
    output logic              capture_o,
    output logic              done_o,
    output logic              ready_o
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    phase_e            phase_q;
    logic [BEAT_W-1:0] beat_q;

    // Advance phase and beat index once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            beat_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (req_valid) begin
                    phase_q <= PH_ADDR;
                    beat_q  <= '0;
                end
                PH_ADDR:  phase_q <= PH_SETUP;
                PH_SETUP: phase_q <= PH_DATA;
                PH_DATA: begin
                    if (beat_q == LAST_BEAT) begin
                        phase_q <= PH_DONE;
                    end else begin
                        phase_q <= PH_ADDR;
                        beat_q  <= beat_q + 1'b1;
                    end
                end
                PH_DONE:  phase_q <= PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    // Decode control strobes from the current phase.
    always_comb begin
        phase_o   = phase_q;
        beat_o    = beat_q;
        ready_o   = (phase_q == PH_IDLE);
        accept_o  = (phase_q == PH_IDLE) && req_valid;
        capture_o = (phase_q == PH_DATA);
        done_o    = (phase_q == PH_DONE);
    end

    // R5: a data clock always follows a setup clock.
    p_setup_then_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA) |-> ($past(phase_q) == PH_SETUP));

    // R10: the done clock is followed by idle.
    p_done_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/nrs_addr_step.sv
// Address and size generator: latches the aligned word address on accept and
// offsets it by one port width per beat. Assumes a little-step byte address space.
module nrs_addr_step #(
    parameter int          ADDR_W     = 32,
    parameter int          BEAT_W     = 2,
    parameter int          STEP       = 1,
    parameter int          ALIGN_BITS = 2,
    parameter logic [1:0]  FIRST_CODE = 2'b00,
    parameter logic [1:0]  LATER_CODE = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        tsiz_o
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((64'd1 << ALIGN_BITS) - 1);

    logic [ADDR_W-1:0] base_q;

    // Hold the word-aligned base of the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (accept_i) begin
            base_q <= req_addr_i & ~ALIGN_MASK;
        end
    end

    // Beat address and size code.
    always_comb begin
        addr_o = base_q + (ADDR_W'(beat_i) * ADDR_W'(STEP));
        tsiz_o = (beat_i == '0) ? FIRST_CODE : LATER_CODE;
    end

    // R6: the base never changes while no request is taken.
    p_base_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(accept_i) |-> $stable(base_q));

endmodule

// File: rtl/nrs_byte_pack.sv
// Byte packer: clears on accept and shifts each captured lane in at the
// bottom, so the first lane ends up most significant.
module nrs_byte_pack #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] word_q;

    // Shift register that assembles the word big-endian.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (clear_i) begin
            word_q <= '0;
        end else if (capture_i) begin
            word_q <= {word_q[WORD_W-LANE_W-1:0], lane_i};
        end
    end

    assign word_o = word_q;

    // R8: a new request can never arrive during a capture clock.
    p_no_clear_in_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear_i && capture_i));

endmodule

// File: rtl/narrow_read_seq.sv
// Top: serves one word read as byte-wide, burst-inhibited transactions on
// a zero-wait external port. Assumes DATA_W is a multiple of PORT_W.
module narrow_read_seq
    import nrs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic [1:0]        bus_tsiz,
    input  logic [PORT_W-1:0] bus_din
);

    localparam int BEATS      = DATA_W / PORT_W;
    localparam int BEAT_W     = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int STEP       = PORT_W / 8;
    localparam int ALIGN_BITS = $clog2(DATA_W / 8);
    localparam logic [1:0] FIRST_CODE = size_code(DATA_W / 8);
    localparam logic [1:0] LATER_CODE = size_code(PORT_W / 8);

    phase_e            phase;
    logic [BEAT_W-1:0] beat;
    logic              accept;
    logic              capture;
    logic              done;

    nrs_phase_fsm #(.BEATS(BEATS), .BEAT_W(BEAT_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .phase_o   (phase),
        .beat_o    (beat),
        .accept_o  (accept),
        .capture_o (capture),
        .done_o    (done),
        .ready_o   (req_ready)
    );

    nrs_addr_step #(
        .ADDR_W     (ADDR_W),
        .BEAT_W     (BEAT_W),
        .STEP       (STEP),
        .ALIGN_BITS (ALIGN_BITS),
        .FIRST_CODE (FIRST_CODE),
        .LATER_CODE (LATER_CODE)
    ) addr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .req_addr_i (req_addr),
        .beat_i     (beat),
        .addr_o     (bus_addr),
        .tsiz_o     (bus_tsiz)
    );

    nrs_byte_pack #(.WORD_W(DATA_W), .LANE_W(PORT_W)) pack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .capture_i (capture),
        .lane_i    (bus_din),
        .word_o    (rsp_data)
    );

    // Bus strobes from the phase: select in setup and data, read in data only.
    always_comb begin
        bus_cs_n  = !((phase == PH_SETUP) || (phase == PH_DATA));
        bus_rd_n  = (phase != PH_DATA);
        rsp_valid = done;
    end

    // R5: the read strobe lasts exactly one clock.
    p_rd_one_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |=> bus_rd_n);

    // R5: the read strobe is preceded by a selected, non-reading setup clock.
    p_setup_before_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |-> ($past(!bus_cs_n) && $past(bus_rd_n)));

    // R9: chip select goes high after every data clock.
    p_gap_after_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |=> bus_cs_n);

    // R9: address and size are already stable the clock before select falls.
    p_addr_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> ($stable(bus_addr) && $stable(bus_tsiz)));

    // R8: no request is offered as accepted while the bus is in use.
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> !req_ready);

    // R10: the done pulse is one clock and ready follows it.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: tb/narrow_read_seq_tb_top.sv
// Directed bench: a zero-wait byte device model and one task per scenario.
module narrow_read_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [31:0] bus_addr;
    logic        bus_cs_n;
    logic        bus_rd_n;
    logic [1:0]  bus_tsiz;
    logic [7:0]  bus_din = 8'hEE;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    narrow_read_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .bus_addr  (bus_addr),
        .bus_cs_n  (bus_cs_n),
        .bus_rd_n  (bus_rd_n),
        .bus_tsiz  (bus_tsiz),
        .bus_din   (bus_din)
    );

    function automatic logic [7:0] dev_byte(input logic [31:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    // Device: drives the addressed byte only during the data clock.
    always @(negedge clk) begin
        if (!bus_cs_n && !bus_rd_n) bus_din <= dev_byte(bus_addr);
        else                        bus_din <= 8'hEE;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // One full read; optionally presents a second request while busy.
    task automatic run_read(input logic [31:0] addr, input bit busy_req);
        logic [31:0] base;
        logic [31:0] exp_word;
        base = {addr[31:2], 2'b00};
        exp_word = {dev_byte(base), dev_byte(base + 1), dev_byte(base + 2), dev_byte(base + 3)};
        @(negedge clk);
        check("R8 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_addr  = addr;
        @(posedge clk);
        for (int c = 1; c <= 14; c++) begin
            @(negedge clk);
            if (c == 1) req_valid = 1'b0;
            if (busy_req && c == 2) begin
                req_valid = 1'b1;
                req_addr  = ~addr;
            end
            if (busy_req && c == 12) req_valid = 1'b0;
            if (c <= 12) begin
                int beat;
                int ph;
                beat = (c - 1) / 3;
                ph   = (c - 1) % 3;
                // R2 / R5 / R9: address, setup, data clocks per transaction.
                check("R2 R9 cs_n schedule", {31'd0, bus_cs_n}, (ph == 0) ? 32'd1 : 32'd0);
                check("R5 rd_n schedule", {31'd0, bus_rd_n}, (ph == 2) ? 32'd0 : 32'd1);
                check("R6 beat address", bus_addr, base + beat);
                if (beat == 0) check("R3 first size code", {30'd0, bus_tsiz}, 32'd0);
                else           check("R4 later size code", {30'd0, bus_tsiz}, 32'd1);
                check("R8 not ready while busy", {31'd0, req_ready}, 32'd0);
                check("R10 no early done", {31'd0, rsp_valid}, 32'd0);
            end else if (c == 13) begin
                check("R10 done pulse", {31'd0, rsp_valid}, 32'd1);
                check("R7 assembled word", rsp_data, exp_word);
                check("R2 no fifth transaction", {31'd0, bus_cs_n}, 32'd1);
            end else begin
                check("R10 done ends", {31'd0, rsp_valid}, 32'd0);
                check("R10 ready returns", {31'd0, req_ready}, 32'd1);
                check("R8 busy request started nothing", {31'd0, bus_cs_n}, 32'd1);
            end
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        req_valid = 1'b1;
        req_addr = 32'h1000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 cs_n in reset", {31'd0, bus_cs_n}, 32'd1);
        check("R1 rd_n in reset", {31'd0, bus_rd_n}, 32'd1);
        check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 ready in reset", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 cs_n after reset", {31'd0, bus_cs_n}, 32'd1);
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic test_aligned();       run_read(32'h0000_1230, 1'b0); endtask
    task automatic test_unaligned();     run_read(32'h0000_45A7, 1'b0); endtask
    task automatic test_busy_ignored();  run_read(32'h0002_0080, 1'b1); endtask
    task automatic test_top_of_space();  run_read(32'hFFFF_FFFE, 1'b0); endtask
    task automatic test_back_to_back();
        run_read(32'h0000_0010, 1'b0);
        run_read(32'h0000_0011, 1'b0);
        run_read(32'h0000_7F7C, 1'b0);
    endtask

    initial begin
        test_reset();
        test_aligned();
        test_unaligned();
        test_busy_ignored();
        test_top_of_space();
        test_back_to_back();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule